// File: doc/BRIEF.md
# Configurable Word Demultiplexer (1:2 / 1:4)

This block takes a fast stream of 11-bit words (ten data bits plus an out-of-range flag) that arrives with a strobe line, and deals consecutive words round-robin onto two or four parallel output ports. Each port then carries half or a quarter of the input word rate, which lets slower downstream logic keep up with a fast converter. Every output word is marked by a data-ready strobe.

The block runs on a system clock that oversamples the input strobe. A capture event is an edge of the input strobe seen between two system clock edges: only rising edges in plain mode, both edges in half-rate mode. Static mode pins choose the split ratio, the strobe style of the data-ready output (one pulse per word, or one toggle per word), and whether the active ports update together under one shared strobe or one after another, each with its own strobe carried on its flag line. An active-low self-test pin replaces the input with a counting pattern, and an active-low sleep pin blanks every output. Mode pins are meant to be changed only while reset is held.

Top module: `word_demux`

## Requirements
- R1: While `rst` is high all outputs are 0, asynchronously; after release the first captured word goes to port A (slot 0), and `dataReady` stays 0 until a port update.
- R2: Captured words go to slots 0,1,2,3 in turn and wrap to 0 when `ratioSel`=1; with `ratioSel`=0 only slots 0 and 1 are used and ports C and D stay 0.
- R3: In simultaneous mode (`staggerN`=1) the out-of-range bit of each word appears on `outOor[k]` together with that word's data on port k.
- R4: With `clkHalf`=0 only a 0-to-1 change of `inClk` captures a word; a 1-to-0 change leaves all data outputs unchanged. With `clkHalf`=1 both changes capture.
- R5: In simultaneous mode no port changes until the word for the last active slot is captured; then all active ports update in the system clock cycle whose rising edge first sees the capture edge.
- R6: In simultaneous mode with `drHalf`=0, `dataReady` is 1 for exactly one system clock cycle per port update; with `drHalf`=1 it inverts once per port update.
- R7: In staggered mode (`staggerN`=0) port k updates on its own capture, `outOor[k]` is port k's strobe (one-cycle pulse when `drHalf`=0, toggle when `drHalf`=1), the flag bit is not output, and `dataReady` is 0.
- R8: With `bistN`=0 the input word is ignored; the n-th word captured since reset (n from 0) carries data n mod 1024 and flag 0.
- R9: With `sleepN`=0 all outputs go to 0 at the next clock edge and captures are ignored; after release the next word goes to slot 0 and the self-test count resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the input strobe |
| rst | input | 1 | Asynchronous reset, active high |
| inClk | input | 1 | Input word strobe |
| inData | input | 10 | Input data bits |
| inOor | input | 1 | Input out-of-range flag |
| ratioSel | input | 1 | 1: four ports, 0: two ports |
| clkHalf | input | 1 | 1: capture on both strobe edges |
| drHalf | input | 1 | 1: strobes toggle per word instead of pulsing |
| staggerN | input | 1 | 0: staggered port updates |
| bistN | input | 1 | 0: self-test counting pattern |
| sleepN | input | 1 | 0: outputs blanked, captures ignored |
| outData | output | 40 | Port data, port k in bits [10k+9:10k] |
| outOor | output | 4 | Per-port flag, or per-port strobe when staggered |
| dataReady | output | 1 | Shared data-ready strobe |

## Verification
Random data and flag words are streamed through every one of the sixteen combinations of ratio, capture-edge, strobe style and stagger mode, with self-test switched on at random, so misrouted slots, lost flags, wrong edge counting and strobe style mix-ups each show up as a different port mismatch. In plain capture mode the falling strobe step is checked separately to tell a rising-only capture from a dual-edge one. A directed sleep run in the middle of a group checks blanking, ignored captures and the restart at port A, and a reset asserted between clock edges checks that clearing does not wait for a clock.

// File: rtl/word_demux_pkg.sv
package word_demux_pkg;
  localparam int MAX_PORTS = 4;
  localparam int SLOT_W = $clog2(MAX_PORTS);

  typedef struct packed {
    logic              capture;
    logic [SLOT_W-1:0] slot;
    logic              lastSlot;
    logic              stagger;
    logic              drHalf;
    logic              sleep;
    logic              bist;
  } ctrl_t;
endpackage

// File: rtl/word_demux_ctrl.sv
module word_demux_ctrl
  import word_demux_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  inClk,
  input  logic  clkHalf,
  input  logic  ratioSel,
  input  logic  drHalf,
  input  logic  staggerN,
  input  logic  bistN,
  input  logic  sleepN,
  output ctrl_t ctrl
);
  localparam logic [SLOT_W-1:0] LAST_FULL = SLOT_W'(MAX_PORTS - 1);
  localparam logic [SLOT_W-1:0] LAST_HALF = SLOT_W'(MAX_PORTS / 2 - 1);

  logic              inClkQ;
  logic [SLOT_W-1:0] slotQ;
  logic              edgeHit;
  logic              atLast;
  logic [SLOT_W-1:0] lastIdx;

  always_comb begin
    edgeHit = clkHalf ? (inClk ^ inClkQ) : (inClk & ~inClkQ);
    lastIdx = ratioSel ? LAST_FULL : LAST_HALF;
    atLast  = (slotQ >= lastIdx);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      inClkQ <= 1'b0;
      slotQ  <= '0;
    end else begin
      inClkQ <= inClk;
      if (!sleepN)
        slotQ <= '0;
      else if (edgeHit)
        slotQ <= atLast ? '0 : slotQ + 1'b1;
    end
  end

  always_comb begin
    ctrl.capture  = edgeHit & sleepN;
    ctrl.slot     = slotQ;
    ctrl.lastSlot = atLast;
    ctrl.stagger  = ~staggerN;
    ctrl.drHalf   = drHalf;
    ctrl.sleep    = ~sleepN;
    ctrl.bist     = ~bistN;
  end

  // R2
  slot_adv_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.capture |=> (slotQ == ($past(atLast) ? '0 : $past(slotQ) + 1'b1)));

  // R9
  sleep_slot_chk: assert property (@(posedge clk) disable iff (rst)
    !sleepN |=> (slotQ == '0));
endmodule

// File: rtl/word_demux_dpath.sv
module word_demux_dpath
  import word_demux_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  ctrl_t                       ctrl,
  input  logic [DATA_W-1:0]           inData,
  input  logic                        inOor,
  output logic [MAX_PORTS*DATA_W-1:0] outData,
  output logic [MAX_PORTS-1:0]        outOor,
  output logic                        dataReady
);
  localparam int WORD_W = DATA_W + 1;

  logic [WORD_W-1:0]    holdQ [MAX_PORTS];
  logic [WORD_W-1:0]    portQ [MAX_PORTS];
  logic [MAX_PORTS-1:0] stbQ;
  logic                 drQ;
  logic [DATA_W-1:0]    bistQ;
  logic [WORD_W-1:0]    newWord;

  always_comb newWord = ctrl.bist ? {1'b0, bistQ} : {inOor, inData};

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int j = 0; j < MAX_PORTS; j++) begin
        holdQ[j] <= '0;
        portQ[j] <= '0;
      end
      stbQ  <= '0;
      drQ   <= 1'b0;
      bistQ <= '0;
    end else if (ctrl.sleep) begin
      for (int j = 0; j < MAX_PORTS; j++) begin
        holdQ[j] <= '0;
        portQ[j] <= '0;
      end
      stbQ <= '0;
      drQ  <= 1'b0;
    end else begin
      if (!ctrl.drHalf) begin
        stbQ <= '0;
        drQ  <= 1'b0;
      end
      if (ctrl.capture) begin
        bistQ <= bistQ + 1'b1;
        if (ctrl.stagger) begin
          for (int j = 0; j < MAX_PORTS; j++) begin
            if (j == int'(ctrl.slot)) begin
              portQ[j] <= newWord;
              stbQ[j]  <= ctrl.drHalf ? ~stbQ[j] : 1'b1;
            end
          end
        end else begin
          for (int j = 0; j < MAX_PORTS; j++) begin
            if (j == int'(ctrl.slot)) holdQ[j] <= newWord;
          end
          if (ctrl.lastSlot) begin
            for (int j = 0; j < MAX_PORTS; j++) begin
              if (j == int'(ctrl.slot))
                portQ[j] <= newWord;
              else if (j < int'(ctrl.slot))
                portQ[j] <= holdQ[j];
            end
            drQ <= ctrl.drHalf ? ~drQ : 1'b1;
          end
        end
      end
    end
  end

  for (genvar k = 0; k < MAX_PORTS; k++) begin : g_port
    assign outData[k*DATA_W +: DATA_W] = portQ[k][DATA_W-1:0];
    assign outOor[k] = ctrl.stagger ? stbQ[k] : portQ[k][DATA_W];
  end

  assign dataReady = ctrl.stagger ? 1'b0 : drQ;

  // R9
  sleep_blank_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.sleep |=> (outData == '0 && outOor == '0 && dataReady == 1'b0));

  // R6
  dr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (dataReady && !ctrl.drHalf) |-> $past(ctrl.capture && ctrl.lastSlot && !ctrl.stagger));

  // R6
  dr_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(drQ) && ctrl.drHalf && $past(ctrl.drHalf) && !$past(ctrl.sleep))
      |-> $past(ctrl.capture && ctrl.lastSlot));

  // R7
  stagger_one_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.stagger && !ctrl.drHalf) |-> $onehot0(stbQ));
endmodule

// File: rtl/word_demux.sv
module word_demux
  import word_demux_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        inClk,
  input  logic [DATA_W-1:0]           inData,
  input  logic                        inOor,
  input  logic                        ratioSel,
  input  logic                        clkHalf,
  input  logic                        drHalf,
  input  logic                        staggerN,
  input  logic                        bistN,
  input  logic                        sleepN,
  output logic [MAX_PORTS*DATA_W-1:0] outData,
  output logic [MAX_PORTS-1:0]        outOor,
  output logic                        dataReady
);
  ctrl_t ctrl;

  word_demux_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inClk    (inClk),
    .clkHalf  (clkHalf),
    .ratioSel (ratioSel),
    .drHalf   (drHalf),
    .staggerN (staggerN),
    .bistN    (bistN),
    .sleepN   (sleepN),
    .ctrl     (ctrl)
  );

  word_demux_dpath #(.DATA_W(DATA_W)) i_dpath (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .inData    (inData),
    .inOor     (inOor),
    .outData   (outData),
    .outOor    (outOor),
    .dataReady (dataReady)
  );
endmodule

// File: tb/test_word_demux.sv
module test_word_demux;
  localparam int DW = 10;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inClk = 1'b0;
  logic [DW-1:0] inData = '0;
  logic inOor = 1'b0;
  logic ratioSel = 1'b1, clkHalf = 1'b0, drHalf = 1'b0;
  logic staggerN = 1'b1, bistN = 1'b1, sleepN = 1'b1;
  logic [NP*DW-1:0] outData;
  logic [NP-1:0] outOor;
  logic dataReady;

  int checks = 0;
  int failures = 0;

  logic [DW:0] expPort [NP];
  logic [DW:0] expHold [NP];
  logic [NP-1:0] expStb;
  logic expDr;
  int ptr;
  logic [DW-1:0] bcnt;

  always #2 clk = ~clk;

  word_demux i_word_demux (
    .clk(clk), .rst(rst), .inClk(inClk), .inData(inData), .inOor(inOor),
    .ratioSel(ratioSel), .clkHalf(clkHalf), .drHalf(drHalf),
    .staggerN(staggerN), .bistN(bistN), .sleepN(sleepN),
    .outData(outData), .outOor(outOor), .dataReady(dataReady)
  );

  function automatic int lastIdx();
    return ratioSel ? NP - 1 : NP / 2 - 1;
  endfunction

  function automatic logic [NP*DW-1:0] expData();
    logic [NP*DW-1:0] v;
    for (int j = 0; j < NP; j++) v[j*DW +: DW] = expPort[j][DW-1:0];
    return v;
  endfunction

  function automatic logic [NP-1:0] expFlag();
    logic [NP-1:0] v;
    for (int j = 0; j < NP; j++) v[j] = staggerN ? expPort[j][DW] : expStb[j];
    return v;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int j = 0; j < NP; j++) begin
      expPort[j] = '0;
      expHold[j] = '0;
    end
    expStb = '0;
    expDr = 1'b0;
    ptr = 0;
  endtask

  task automatic modelCapture(logic [DW-1:0] d, logic f);
    logic [DW:0] w;
    w = !bistN ? {1'b0, bcnt} : {f, d};
    bcnt++;
    if (!drHalf) begin
      expStb = '0;
      expDr = 1'b0;
    end
    if (!staggerN) begin
      expPort[ptr] = w;
      expStb[ptr] = drHalf ? ~expStb[ptr] : 1'b1;
    end else begin
      expHold[ptr] = w;
      if (ptr == lastIdx()) begin
        for (int j = 0; j <= ptr; j++) expPort[j] = (j == ptr) ? w : expHold[j];
        expDr = drHalf ? ~expDr : 1'b1;
      end
    end
    ptr = (ptr == lastIdx()) ? 0 : ptr + 1;
  endtask

  task automatic modelIdle();
    if (!drHalf) begin
      expStb = '0;
      expDr = 1'b0;
    end
  endtask

  task automatic checkAll(string ctx);
    string dtag;
    dtag = !bistN ? "R8 data" : (!staggerN ? "R7/R2 data" : "R5/R2 data");
    check($sformatf("%s %s", dtag, ctx), 64'(outData), 64'(expData()));
    check($sformatf("%s flags", !staggerN ? "R7" : "R3"), 64'(outOor), 64'(expFlag()));
    check("R6 dataReady", 64'(dataReady), 64'(staggerN ? expDr : 1'b0));
  endtask

  task automatic doReset();
    @(negedge clk);
    #1 rst = 1'b1;
    inClk = 1'b0;
    #0.5;
    check("R1 async clear data", 64'(outData), 64'd0);
    check("R1 async clear strobes", 64'({outOor, dataReady}), 64'd0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    modelClear();
    bcnt = '0;
    @(negedge clk);
    check("R1 reset state", 64'({outData, outOor, dataReady}), 64'd0);
  endtask

  task automatic sendWord(logic [DW-1:0] d, logic f);
    inData = d;
    inOor = f;
    inClk = clkHalf ? ~inClk : 1'b1;
    @(negedge clk);
    if (sleepN) modelCapture(d, f);
    else begin
      modelClear();
    end
    checkAll("capture");
    if (!clkHalf) begin
      inClk = 1'b0;
      @(negedge clk);
      if (sleepN) modelIdle();
      checkAll("R4 falling step");
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    modelClear();
    bcnt = '0;
    for (int cfg = 0; cfg < 16; cfg++) begin
      @(negedge clk);
      rst = 1'b1;
      ratioSel = cfg[0];
      clkHalf = cfg[1];
      drHalf = cfg[2];
      staggerN = cfg[3];
      bistN = ($urandom % 3) != 0;
      doReset();
      for (int n = 0; n < 12; n++)
        sendWord(DW'($urandom), 1'($urandom));
    end

    // directed: sleep mid-group, simultaneous 1:4, plain strobes, self-test
    @(negedge clk);
    rst = 1'b1;
    ratioSel = 1'b1; clkHalf = 1'b0; drHalf = 1'b0; staggerN = 1'b1; bistN = 1'b0;
    doReset();
    for (int n = 0; n < 6; n++) sendWord(DW'($urandom), 1'b1);
    sleepN = 1'b0;
    @(negedge clk);
    modelClear();
    check("R9 sleep blanks outputs", 64'({outData, outOor, dataReady}), 64'd0);
    sendWord(10'h155, 1'b1);
    sendWord(10'h0aa, 1'b1);
    check("R9 captures ignored in sleep", 64'({outData, outOor, dataReady}), 64'd0);
    sleepN = 1'b1;
    @(negedge clk);
    for (int n = 0; n < 4; n++) sendWord(DW'($urandom), 1'b0);
    check("R9 restart at A with count resumed", 64'(outData[DW-1:0]), 64'd6);

    // directed: staggered 1:2, port C/D remain zero, port A pulse after one word
    @(negedge clk);
    rst = 1'b1;
    ratioSel = 1'b0; clkHalf = 1'b1; drHalf = 1'b0; staggerN = 1'b0; bistN = 1'b1;
    doReset();
    sendWord(10'h3ff, 1'b1);
    check("R7 port A strobe after first word", 64'(outOor), 64'h1);
    sendWord(10'h001, 1'b1);
    sendWord(10'h002, 1'b0);
    check("R2 ports C and D unused in 1:2", 64'(outData[NP*DW-1:2*DW]), 64'd0);
    check("R2 wrap to A", 64'(outData[DW-1:0]), 64'h002);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule